// File: doc/BRIEF.md
# Cycle-Locked Machine Timer

A core-local timer for one 64-bit hart. A cycle counter advances on every clock. A prescaler divides that count by a fixed integer (100 by default) and advances a 64-bit machine time register once per division period. Time therefore stays an exact function of the cycles executed, and nothing depends on a wall clock. A 64-bit compare register is held next to the time register. A level-sensitive machine timer interrupt is raised whenever time and compare hold the same value.

Software reaches the time and compare registers through a simple single-cycle register port. It carries a request strobe, a write enable, a 32-bit physical address and 64-bit data. Read data is combinational and valid in the same cycle as a read request. A write takes effect at the next clock edge. The device decodes a fixed physical window. Only two word addresses inside that window are backed by registers.

Top module: `cyc_timer`

## Requirements
- R1: `cycle_o` increases by exactly one on every clock edge while reset is released.
- R2: Machine time increases by one at every edge where the prescaler wraps from DIVISOR-1 to 0. Without time writes it equals floor(cycle_o / 100) with the default DIVISOR of 100. It is 0 at cycle 99 and 1 at cycle 100.
- R3: The time register is read and written as a full 64-bit word at address 0x0200BFF8. A write replaces its value at the next edge, and this write wins over a coincident increment. The prescaler phase is not disturbed by a time write.
- R4: The compare register is read and written as a full 64-bit word at address 0x02004000.
- R5: `irq_o` is high exactly while the time value equals the compare value, and it stays high for as long as equality holds. With the default divisor, a compare value hit by counting keeps `irq_o` high for exactly 100 cycles.
- R6: Writing a compare value that differs from the current time drops `irq_o` from the next cycle. Writing the current time value raises it from the next cycle.
- R7: The device window is 0x02000000 to 0x020BFFFF. Reads of any other address in the window, or of any address outside it, return zero. Writes to those addresses change no register.
- R8: Reset (active-low, asynchronous) clears the cycle counter, prescaler and time register to zero and sets the compare register to all ones, so `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Hart clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Physical byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid in the cycle of a read request, zero otherwise |
| cycle_o | output | 64 | Free-running cycle count |
| irq_o | output | 1 | Machine timer interrupt, level |

## Verification
The hardest case to reach is a time write that lands on the same edge as a prescaler wrap. The stimulus waits until `cycle_o` shows the last cycle of a division period and writes time in that cycle. It then checks that the written value holds and that the next increment still arrives exactly 100 cycles later. The interrupt window is checked by sampling every cycle across a whole time step, which confirms that the level lasts exactly one division period. A vector table covers register read-back and unmapped addresses, including an address just outside the window that aliases the compare offset.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
package cyc_timer_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TIME = 2'd1,
    SEL_CMP  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cyc_timer_prescale.sv
`timescale 1ns/1ps
module cyc_timer_prescale #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned DIVISOR = 100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] cycle_o,
  output logic            tick_o
);
  logic [XLEN-1:0] cycle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cycle_q <= '0;
    else         cycle_q <= cycle_q + 1'b1;
  end

  assign cycle_o = cycle_q;

  generate
    if (DIVISOR > 1) begin : g_div
      localparam int unsigned PW = $clog2(DIVISOR);
      localparam logic [PW-1:0] LAST = PW'(DIVISOR - 1);
      logic [PW-1:0] pre_q;
      logic          wrap;

      assign wrap   = (pre_q == LAST);
      assign tick_o = wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pre_q <= '0;
        else if (wrap) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end

      a_r2_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_q <= LAST);
      a_r2_pre_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> pre_q == '0);
      a_r2_pre_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> pre_q == $past(pre_q) + 1'b1);
      // prescaler phase stays locked to the cycle count
      a_r2_tick_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o == ((cycle_q % XLEN'(DIVISOR)) == XLEN'(DIVISOR - 1)));
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

  a_r1_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cycle_q == $past(cycle_q) + 1'b1);
endmodule

// File: rtl/cyc_timer_decode.sv
`timescale 1ns/1ps
module cyc_timer_decode
  import cyc_timer_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] BASE     = 32'h0200_0000,
  parameter logic [AW-1:0] SPAN     = 32'h000C_0000,
  parameter logic [AW-1:0] TIME_OFF = 32'h0000_BFF8,
  parameter logic [AW-1:0] CMP_OFF  = 32'h0000_4000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o,
  output logic          wr_time_o,
  output logic          wr_cmp_o
);
  localparam logic [AW-1:0] LIMIT = BASE + SPAN;

  logic          in_win;
  logic [AW-1:0] off;

  assign in_win = (addr_i >= BASE) && (addr_i < LIMIT);
  assign off    = addr_i - BASE;

  always_comb begin
    sel_o = SEL_NONE;
    if (in_win) begin
      if (off == TIME_OFF)     sel_o = SEL_TIME;
      else if (off == CMP_OFF) sel_o = SEL_CMP;
    end
  end

  assign wr_time_o = req_i && we_i && (sel_o == SEL_TIME);
  assign wr_cmp_o  = req_i && we_i && (sel_o == SEL_CMP);

  a_r7_no_dual_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_time_o, wr_cmp_o}));
  a_r7_outside_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> !wr_time_o && !wr_cmp_o);
endmodule

// File: rtl/cyc_timer_time.sv
`timescale 1ns/1ps
module cyc_timer_time #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] time_o
);
  logic [XLEN-1:0] time_q;

  // software write wins over a coincident increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (wr_i)   time_q <= wdata_i;
    else if (tick_i) time_q <= time_q + 1'b1;
  end

  assign time_o = time_q;

  a_r3_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> time_q == $past(wdata_i));
  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && tick_i |=> time_q == $past(time_q) + 1'b1);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !tick_i |=> $stable(time_q));
endmodule

// File: rtl/cyc_timer_cmp.sv
`timescale 1ns/1ps
module cyc_timer_cmp #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] time_i,
  output logic [XLEN-1:0] cmp_o,
  output logic            irq_o
);
  logic [XLEN-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '1;
    else if (wr_i) cmp_q <= wdata_i;
  end

  assign cmp_o = cmp_q;
  assign irq_o = (cmp_q == time_i);

  a_r4_cmp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cmp_q == $past(wdata_i));
  a_r4_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cmp_q));
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned   XLEN     = 64,
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DIVISOR  = 100,
  parameter logic [AW-1:0] BASE     = 32'h0200_0000,
  parameter logic [AW-1:0] SPAN     = 32'h000C_0000,
  parameter logic [AW-1:0] TIME_OFF = 32'h0000_BFF8,
  parameter logic [AW-1:0] CMP_OFF  = 32'h0000_4000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] cycle_o,
  output logic            irq_o
);
  reg_sel_e        sel;
  logic            wr_time, wr_cmp, tick;
  logic [XLEN-1:0] time_val, cmp_val;

  cyc_timer_prescale #(.XLEN(XLEN), .DIVISOR(DIVISOR)) u_prescale (
    .clk_i, .rst_ni, .cycle_o, .tick_o(tick)
  );

  cyc_timer_decode #(
    .AW(AW), .BASE(BASE), .SPAN(SPAN), .TIME_OFF(TIME_OFF), .CMP_OFF(CMP_OFF)
  ) u_decode (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .sel_o(sel), .wr_time_o(wr_time), .wr_cmp_o(wr_cmp)
  );

  cyc_timer_time #(.XLEN(XLEN)) u_time (
    .clk_i, .rst_ni, .tick_i(tick), .wr_i(wr_time), .wdata_i, .time_o(time_val)
  );

  cyc_timer_cmp #(.XLEN(XLEN)) u_cmp (
    .clk_i, .rst_ni, .wr_i(wr_cmp), .wdata_i, .time_i(time_val),
    .cmp_o(cmp_val), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_TIME: rdata_o = time_val;
        SEL_CMP:  rdata_o = cmp_val;
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r6_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp && !wr_time && !tick && (wdata_i != time_val) |=> !irq_o);
  a_r6_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp && !wr_time && !tick && (wdata_i == time_val) |=> irq_o);
  a_r5_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_cmp && !wr_time && !tick |=> irq_o);
  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (sel == SEL_NONE) |-> rdata_o == '0);
endmodule

// File: tb/cyc_timer_test.sv
`timescale 1ns/1ps
module cyc_timer_test;
  localparam logic [31:0] A_TIME = 32'h0200_BFF8;
  localparam logic [31:0] A_CMP  = 32'h0200_4000;
  localparam int NV = 12;
  // [161] we, [160:129] addr, [128:65] wdata, [64:1] expected read, [0] check
  typedef logic [161:0] vec_t;
  localparam vec_t TBL [NV] = '{
    {1'b1, A_CMP,        64'h1234,                 64'h0,                    1'b0},
    {1'b0, A_CMP,        64'h0,                    64'h1234,                 1'b1},
    {1'b0, 32'h0200_0000, 64'h0,                   64'h0,                    1'b1},
    {1'b1, 32'h0200_0008, 64'hDEAD,                64'h0,                    1'b0},
    {1'b0, 32'h0200_0008, 64'h0,                   64'h0,                    1'b1},
    {1'b0, 32'h0200_BFF0, 64'h0,                   64'h0,                    1'b1},
    {1'b1, 32'h020C_4000, 64'h55,                  64'h0,                    1'b0},
    {1'b0, A_CMP,        64'h0,                    64'h1234,                 1'b1},
    {1'b0, 32'h020C_4000, 64'h0,                   64'h0,                    1'b1},
    {1'b0, 32'h01FF_FFF8, 64'h0,                   64'h0,                    1'b1},
    {1'b1, A_CMP,        64'hFFFF_0000_AAAA_5555, 64'h0,                    1'b0},
    {1'b0, A_CMP,        64'h0,                    64'hFFFF_0000_AAAA_5555, 1'b1}
  };

  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, cycle;
  logic        irq;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  cyc_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cycle_o(cycle), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_cycle(input logic [63:0] n);
    while (cycle != n) @(negedge clk);
  endtask

  initial begin
    logic [63:0] d, c0, t;
    int mism, hi;
    // R8: reset values while reset held
    #1 req = 1'b1; addr = A_TIME;
    #1 check(rdata == 64'h0, "R8 time at reset", rdata, 64'h0);
    addr = A_CMP;
    #1 check(rdata == '1, "R8 compare at reset", rdata, '1);
    check(irq == 1'b0, "R8 irq at reset", {63'h0, irq}, 64'h0);
    req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    #1 check(cycle == 64'h0, "R8 cycle at reset", cycle, 64'h0);

    // R1
    @(negedge clk); c0 = cycle;
    @(negedge clk);
    check(cycle == c0 + 1, "R1 cycle step", cycle, c0 + 1);

    // R2: time boundaries
    wait_cycle(98);
    rd(A_TIME, d); check(d == 64'd0, "R2 time at cycle 99", d, 64'd0);
    rd(A_TIME, d); check(d == 64'd1, "R2 time at cycle 100", d, 64'd1);
    wait_cycle(248);
    rd(A_TIME, d); check(d == 64'd2, "R2 time at cycle 249", d, 64'd2);

    // R4 R7: vector table
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      if (v[161]) wr(v[160:129], v[128:65]);
      else begin
        rd(v[160:129], d);
        if (v[0]) check(d == v[64:1], $sformatf("R4/R7 vector %0d", k), d, v[64:1]);
      end
    end

    // R3: time write, prescaler phase kept
    wait_cycle(320);
    wr(A_TIME, 64'd500);
    rd(A_TIME, d); check(d == 64'd500, "R3 time write", d, 64'd500);
    wait_cycle(399);
    rd(A_TIME, d); check(d == 64'd501, "R3 phase after write", d, 64'd501);
    // R3: write coincident with wrap wins
    wait_cycle(498);
    wr(A_TIME, 64'd7);
    rd(A_TIME, d); check(d == 64'd7, "R3 write beats tick", d, 64'd7);
    wait_cycle(599);
    rd(A_TIME, d); check(d == 64'd8, "R3 next tick after collision", d, 64'd8);

    // R5: level window of exactly one period
    wr(A_CMP, 64'd10);
    mism = 0; hi = 0;
    while (cycle < 64'd1150) begin
      rd(A_TIME, t);
      if (irq != (t == 64'd10)) mism++;
      if (irq) hi++;
    end
    check(mism == 0, "R5 irq equals time==cmp", 64'(mism), 64'd0);
    check(hi == 100, "R5 irq high cycles", 64'(hi), 64'd100);

    // R6: compare writes raise and drop irq
    rd(A_TIME, t);
    wr(A_CMP, t);
    rd(A_TIME, d); check(irq == 1'b1, "R6 cmp write to time raises irq", {63'h0, irq}, 64'h1);
    wr(A_CMP, t + 5);
    rd(A_TIME, d); check(irq == 1'b0, "R6 cmp write drops irq", {63'h0, irq}, 64'h0);

    // R8: reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    req = 1'b1; addr = A_CMP;
    #1 check(rdata == '1, "R8 compare after reset", rdata, '1);
    check(cycle == 64'h0, "R8 cycle after reset", cycle, 64'h0);
    req = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule